// File: doc/BRIEF.md
# Two-Mode Priority Interrupt Controller

This block collects interrupt requests for a processor core and offers one winning request at a time. The sources are a non-maskable input, eight external request lines and a set of internal peripheral request lines. The block presents the winner's vector number and level on a valid/ready output stream. Each external line passes through a two-flop synchronizer. A per-line sense field then decides whether a low level, a falling edge, a rising edge or either edge sets that line's sticky flag. Peripheral requests are level signals from the same clock domain and are taken as they are.

Two acceptance modes exist. In the global mode a single mask bit from the core blocks every maskable request. In the level mode each request carries the 3-bit level of the priority group it belongs to, and it is accepted only if that level is strictly above the core's current 3-bit mask level. A small write/read register port holds the mode, the group levels and the sense fields, and lets software clear flags.

The output stream follows valid/ready rules. `irq_valid_o` stays high while any accepted request remains. The presented vector may change before the handshake if a more urgent request appears. A cycle with both `irq_valid_o` and `irq_ready_i` high is the acknowledge for the vector shown in that cycle. The block never drops a request because the core is not ready.

Top module: `prio_intc`

## Requirements
- R1: After reset, `irq_valid_o` is 0 and every register reads 0: the mode, all group levels, all sense fields (low level) and all flags.
- R2: A rising edge on `nmi_i` makes a request that is presented with vector 7 and level 7. It is presented in any mode and under any mask, and ahead of every other request. The handshake clears it, and only a new rising edge raises it again.
- R3: Each external line i has a 2-bit sense field at bits [2i+1:2i] of register 2. The codes are 00 low level, 01 falling edge, 10 rising edge and 11 both edges, all judged on the synchronized input.
- R4: Register 3 bits [7:0] read the external line flags. Writing a 0 to a bit clears that flag. Writing a 1 leaves it unchanged.
- R5: External line i presents vector 16+i. Peripheral request j presents vector 24+j.
- R6: When register 0 bit 1 is 0 (global mode), `cpu_imask_i`=1 blocks all maskable requests. When `cpu_imask_i`=0, the pending request with the lowest vector wins.
- R7: When register 0 bit 1 is 1 (level mode), a maskable request is accepted only if its group level is strictly greater than `cpu_level_i`. The highest level wins, and the lowest vector wins among equal levels.
- R8: Group k's level sits in register 1 bits [3k+2:3k]. External lines 2k and 2k+1 share group k, and peripheral lines 2k and 2k+1 share group 4+k. A handshake clears the flag of an edge-sensed winner. While the core holds ready low, the request stays presented.
- R9: A line sensed at low level stays pending while its input is low, through both handshakes and software clears. After the input returns high, its flag stays set until software clears it.
- R10: Only register 0 bit 1 selects the mode. Bit 0 is stored and read back but has no effect on acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| nmi_i | input | 1 | Non-maskable request, rising edge sensed |
| ext_irq_i | input | 8 | External request lines, idle high |
| per_req_i | input | 8 | Internal peripheral level requests |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select: 0 mode, 1 levels, 2 sense, 3 flags |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` |
| cpu_imask_i | input | 1 | Global mask bit from the core |
| cpu_level_i | input | 3 | Core mask level for level mode |
| irq_valid_o | output | 1 | A request is presented |
| irq_ready_i | input | 1 | Core accepts the presented request |
| irq_vector_o | output | 8 | Vector number of the presented request |
| irq_level_o | output | 3 | Level of the presented request |

## Verification
A flag stuck set shows as a vector that will not go away after its handshake. A lost flag shows as `irq_valid_o` staying low three clock edges after the pin change, which is the latency through the synchronizer and the flag. A wrong group mapping or comparison shows at once as the wrong vector, or as a request that crosses a mask level equal to its own. Register 3 lets the flags be seen even while masking hides them.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;
  localparam int LVL_W = 3;
  localparam int VEC_W = 8;
  localparam logic [VEC_W-1:0] NMI_VEC = 8'd7;
  localparam logic [1:0] A_MODE  = 2'd0;
  localparam logic [1:0] A_PRIO  = 2'd1;
  localparam logic [1:0] A_SENSE = 2'd2;
  localparam logic [1:0] A_FLAG  = 2'd3;
  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_FALL = 2'b01,
    SENSE_RISE = 2'b10,
    SENSE_BOTH = 2'b11
  } sense_e;
endpackage

// File: rtl/prio_intc_line.sv
module prio_intc_line
  import prio_intc_pkg::*;
#(
  parameter bit IDLE = 1'b1
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   pin_i,
  input  sense_e sense_i,
  input  logic   ack_i,
  input  logic   swclr_i,
  output logic   flag_o
);
  logic s1_q, s2_q, prev_q, hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= IDLE;
      s2_q   <= IDLE;
      prev_q <= IDLE;
    end else begin
      s1_q   <= pin_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  always_comb begin
    unique case (sense_i)
      SENSE_LOW:  hit = !s2_q;
      SENSE_FALL: hit = prev_q && !s2_q;
      SENSE_RISE: hit = !prev_q && s2_q;
      default:    hit = prev_q ^ s2_q;
    endcase
  end

  // detection wins over any clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                       flag_o <= 1'b0;
    else if (hit)                                     flag_o <= 1'b1;
    else if (swclr_i || (ack_i && sense_i != SENSE_LOW)) flag_o <= 1'b0;
  end

  assert_ack_clears_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && sense_i != SENSE_LOW && !hit) |=> !flag_o);
  assert_low_stays_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sense_i == SENSE_LOW && !s2_q) |=> flag_o);
endmodule

// File: rtl/prio_intc_arb.sv
module prio_intc_arb
  import prio_intc_pkg::*;
#(
  parameter int NSRC  = 16,
  localparam int IDX_W = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]            req_i,
  input  logic [NSRC-1:0][LVL_W-1:0] lvl_i,
  input  logic                       lvl_mode_i,
  input  logic                       imask_i,
  input  logic [LVL_W-1:0]           cpu_lvl_i,
  output logic                       win_valid_o,
  output logic [IDX_W-1:0]           win_idx_o,
  output logic [LVL_W-1:0]           win_lvl_o
);
  logic             ok;
  logic [LVL_W-1:0] eff, best;

  // scan from the top index down so that ">=" hands ties to the lower index
  always_comb begin
    win_valid_o = 1'b0;
    win_idx_o   = '0;
    win_lvl_o   = '0;
    best        = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      ok  = req_i[i] && (lvl_mode_i ? (lvl_i[i] > cpu_lvl_i) : !imask_i);
      eff = lvl_mode_i ? lvl_i[i] : '0;
      if (ok && (!win_valid_o || eff >= best)) begin
        win_valid_o = 1'b1;
        win_idx_o   = IDX_W'(i);
        win_lvl_o   = lvl_i[i];
        best        = eff;
      end
    end
  end
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import prio_intc_pkg::*;
#(
  parameter int N_EXT        = 8,
  parameter int N_PER        = 8,
  parameter int GRP_SZ       = 2,
  parameter int EXT_VEC_BASE = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             nmi_i,
  input  logic [N_EXT-1:0] ext_irq_i,
  input  logic [N_PER-1:0] per_req_i,
  input  logic             reg_wr_i,
  input  logic [1:0]       reg_addr_i,
  input  logic [31:0]      reg_wdata_i,
  output logic [31:0]      reg_rdata_o,
  input  logic             cpu_imask_i,
  input  logic [2:0]       cpu_level_i,
  output logic             irq_valid_o,
  input  logic             irq_ready_i,
  output logic [7:0]       irq_vector_o,
  output logic [2:0]       irq_level_o
);
  localparam int NSRC  = N_EXT + N_PER;
  localparam int NGRP  = NSRC / GRP_SZ;
  localparam int IDX_W = $clog2(NSRC);

  logic [1:0]                  mode_q;
  logic [NGRP-1:0][LVL_W-1:0]  prio_q;
  logic [N_EXT-1:0][1:0]       sense_q;
  logic [N_EXT-1:0]            ext_flag;
  logic [NSRC-1:0][LVL_W-1:0]  src_lvl;
  logic                        nmi_flag, hs, win_valid, flag_wr;
  logic [IDX_W-1:0]            win_idx;
  logic [LVL_W-1:0]            win_lvl;
  logic                        unused_wdata;

  assign unused_wdata = ^reg_wdata_i;
  assign hs      = irq_valid_o && irq_ready_i;
  assign flag_wr = reg_wr_i && reg_addr_i == A_FLAG;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      prio_q  <= '0;
      sense_q <= '0;
    end else if (reg_wr_i) begin
      case (reg_addr_i)
        A_MODE:  mode_q <= reg_wdata_i[1:0];
        A_PRIO:  for (int g = 0; g < NGRP; g++) prio_q[g] <= reg_wdata_i[LVL_W*g +: LVL_W];
        A_SENSE: for (int e = 0; e < N_EXT; e++) sense_q[e] <= reg_wdata_i[2*e +: 2];
        default: ;
      endcase
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_MODE:  reg_rdata_o[1:0]             = mode_q;
      A_PRIO:  reg_rdata_o[LVL_W*NGRP-1:0]  = prio_q;
      A_SENSE: reg_rdata_o[2*N_EXT-1:0]     = sense_q;
      default: reg_rdata_o[N_EXT-1:0]       = ext_flag;
    endcase
  end

  prio_intc_line #(.IDLE(1'b0)) u_nmi (
    .clk(clk), .rst_n(rst_n), .pin_i(nmi_i), .sense_i(SENSE_RISE),
    .ack_i(hs && nmi_flag), .swclr_i(1'b0), .flag_o(nmi_flag)
  );

  for (genvar e = 0; e < N_EXT; e++) begin : g_ext
    prio_intc_line #(.IDLE(1'b1)) u_line (
      .clk(clk), .rst_n(rst_n), .pin_i(ext_irq_i[e]), .sense_i(sense_e'(sense_q[e])),
      .ack_i(hs && !nmi_flag && win_idx == IDX_W'(e)),
      .swclr_i(flag_wr && !reg_wdata_i[e]), .flag_o(ext_flag[e])
    );
  end

  for (genvar s = 0; s < NSRC; s++) begin : g_lvl
    assign src_lvl[s] = prio_q[s / GRP_SZ];
  end

  prio_intc_arb #(.NSRC(NSRC)) u_arb (
    .req_i({per_req_i, ext_flag}), .lvl_i(src_lvl), .lvl_mode_i(mode_q[1]),
    .imask_i(cpu_imask_i), .cpu_lvl_i(cpu_level_i),
    .win_valid_o(win_valid), .win_idx_o(win_idx), .win_lvl_o(win_lvl)
  );

  assign irq_valid_o  = nmi_flag || win_valid;
  assign irq_vector_o = nmi_flag ? NMI_VEC : VEC_W'(EXT_VEC_BASE) + VEC_W'(win_idx);
  assign irq_level_o  = nmi_flag ? 3'd7 : win_lvl;

  assert_nmi_presented_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_flag && !irq_ready_i) |=> (irq_valid_o && irq_vector_o == NMI_VEC));
  assert_global_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q[1] && cpu_imask_i && !nmi_flag) |-> !irq_valid_o);
  assert_level_strict_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid_o && mode_q[1] && irq_vector_o != NMI_VEC) |-> irq_level_o > cpu_level_i);
  assert_vector_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid_o |-> (irq_vector_o == NMI_VEC ||
      (irq_vector_o >= VEC_W'(EXT_VEC_BASE) && irq_vector_o < VEC_W'(EXT_VEC_BASE + NSRC))));
endmodule

// File: tb/prio_intc_test.sv
module prio_intc_test;
  logic        clk = 1'b0, rst_n = 1'b0, nmi = 1'b0;
  logic [7:0]  ext = 8'hFF, per = 8'h00;
  logic        reg_wr = 1'b0, imask = 1'b0, ready = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [2:0]  cpu_level = 3'd0, irq_level;
  logic        irq_valid;
  logic [7:0]  irq_vector;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  prio_intc uut (
    .clk(clk), .rst_n(rst_n), .nmi_i(nmi), .ext_irq_i(ext), .per_req_i(per),
    .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .cpu_imask_i(imask), .cpu_level_i(cpu_level), .irq_valid_o(irq_valid),
    .irq_ready_i(ready), .irq_vector_o(irq_vector), .irq_level_o(irq_level)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output int d);
    reg_addr = a; #1; d = int'(reg_rdata);
  endtask

  task automatic ack();
    ready = 1'b1;
    @(negedge clk);
    ready = 1'b0;
    #1;
  endtask

  task automatic t_reset();
    int d;
    chk("R1", "valid", irq_valid, 0);
    rd(2'd0, d); chk("R1", "mode", d, 0);
    rd(2'd1, d); chk("R1", "levels", d, 0);
    rd(2'd2, d); chk("R1", "sense", d, 0);
    rd(2'd3, d); chk("R1", "flags", d, 0);
  endtask

  task automatic t_nmi();
    wr(2'd0, 32'h2); cpu_level = 3'd7; imask = 1'b1;
    nmi = 1'b1; tick(5);
    chk("R2", "valid", irq_valid, 1);
    chk("R2", "vector", irq_vector, 7);
    chk("R2", "level", irq_level, 7);
    ack();
    chk("R2", "cleared while high", irq_valid, 0);
    nmi = 1'b0; wr(2'd0, 32'h0); imask = 1'b0; cpu_level = 3'd0;
    per[0] = 1'b1; tick(1);
    chk("R5", "peripheral 0 vector", irq_vector, 24);
    nmi = 1'b1; tick(5);
    chk("R2", "beats peripheral", irq_vector, 7);
    ack();
    chk("R2", "peripheral after nmi", irq_vector, 24);
    per[0] = 1'b0; nmi = 1'b0; tick(4);
    chk("R2", "idle", irq_valid, 0);
  endtask

  task automatic t_fall();
    int d;
    wr(2'd2, 32'h1 << 6);
    ext[3] = 1'b0; tick(5);
    chk("R3", "fall valid", irq_valid, 1);
    chk("R5", "line 3 vector", irq_vector, 19);
    rd(2'd3, d); chk("R4", "flag 3", d, 8'h08);
    ack();
    chk("R8", "edge cleared", irq_valid, 0);
    rd(2'd3, d); chk("R8", "flag after ack", d, 0);
    ext[3] = 1'b1; tick(5);
    chk("R3", "no rise on fall line", irq_valid, 0);
  endtask

  task automatic t_rise_both();
    wr(2'd2, (32'h2 << 10) | (32'h3 << 2));
    ext[5] = 1'b0; tick(5);
    chk("R3", "rise line ignores fall", irq_valid, 0);
    ext[5] = 1'b1; tick(5);
    chk("R3", "rise vector", irq_vector, 21);
    ack();
    ext[1] = 1'b0; tick(5);
    chk("R3", "both: fall", irq_vector, 17);
    ack();
    chk("R3", "both: cleared", irq_valid, 0);
    ext[1] = 1'b1; tick(5);
    chk("R3", "both: rise", irq_vector, 17);
    ack();
    chk("R3", "both: idle", irq_valid, 0);
  endtask

  task automatic t_level();
    wr(2'd2, 32'h0);
    ext[0] = 1'b0; tick(5);
    chk("R3", "low level vector", irq_vector, 16);
    ack();
    chk("R9", "pending after ack", irq_valid, 1);
    wr(2'd3, 32'h0); #1;
    chk("R9", "pending after clear", irq_valid, 1);
    ext[0] = 1'b1; tick(5);
    chk("R9", "sticky after release", irq_valid, 1);
    wr(2'd3, 32'h0); #1;
    chk("R9", "cleared after release", irq_valid, 0);
  endtask

  task automatic t_swclr();
    int d;
    wr(2'd2, 32'h1 << 8);
    ext[4] = 1'b0; tick(5);
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd3, d); chk("R4", "write 1 keeps", d, 8'h10);
    wr(2'd3, 32'hFFFF_FFEF);
    rd(2'd3, d); chk("R4", "write 0 clears", d, 0);
    chk("R4", "valid after clear", irq_valid, 0);
    ext[4] = 1'b1; tick(4);
  endtask

  task automatic t_mode0();
    wr(2'd2, (32'h1 << 4) | (32'h1 << 12));
    imask = 1'b1;
    ext[2] = 1'b0; ext[6] = 1'b0; tick(5);
    chk("R6", "masked", irq_valid, 0);
    imask = 1'b0; #1;
    chk("R6", "lowest vector wins", irq_vector, 18);
    ack();
    chk("R6", "next vector", irq_vector, 22);
    ack();
    chk("R6", "drained", irq_valid, 0);
    ext[2] = 1'b1; ext[6] = 1'b1; tick(4);
  endtask

  task automatic t_mode2();
    wr(2'd0, 32'h2);
    wr(2'd1, (32'd4 << 15) | (32'd2 << 9));
    wr(2'd2, 32'h1 << 12);
    per[3] = 1'b1; ext[6] = 1'b0; cpu_level = 3'd3; tick(5);
    chk("R7", "level winner", irq_vector, 27);
    chk("R8", "group 5 level", irq_level, 4);
    cpu_level = 3'd4; #1;
    chk("R7", "equal level blocked", irq_valid, 0);
    wr(2'd1, (32'd4 << 15) | (32'd6 << 9)); #1;
    chk("R7", "higher level wins", irq_vector, 22);
    cpu_level = 3'd6; #1;
    chk("R7", "all at or below mask", irq_valid, 0);
    cpu_level = 3'd0;
    wr(2'd1, (32'd4 << 15) | (32'd4 << 9)); #1;
    chk("R7", "tie lowest vector", irq_vector, 22);
    ack();
    chk("R7", "after ack", irq_vector, 27);
    imask = 1'b1; wr(2'd0, 32'h1); #1;
    chk("R10", "bit0 alone is global mode", irq_valid, 0);
    wr(2'd0, 32'h3); #1;
    chk("R10", "bit1 selects level mode", irq_vector, 27);
    per[3] = 1'b0; ext[6] = 1'b1; imask = 1'b0;
    wr(2'd0, 32'h0); wr(2'd1, 32'h0); tick(4);
  endtask

  task automatic t_backpressure();
    wr(2'd2, 32'h1 << 14);
    ext[7] = 1'b0; tick(5);
    for (int c = 0; c < 6; c++) begin
      chk("R8", "held valid", irq_valid, 1);
      chk("R8", "held vector", irq_vector, 23);
      tick(1);
    end
    ack();
    chk("R8", "released", irq_valid, 0);
    ext[7] = 1'b1; tick(4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick(2);
    t_reset();
    t_nmi();
    t_fall();
    t_rise_both();
    t_level();
    t_swclr();
    t_mode0();
    t_mode2();
    t_backpressure();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule